// File: doc/BRIEF.md
# Clock Synthesizer Strap and Mode Controller

This block is the digital control core of a multi-output clock synthesizer. During the power-good window it samples the configuration straps. These are the five frequency-select bits, the two early-PCI skew straps and the AGP/PCI async-select strap, and the block holds them once that window closes. A simple parallel write port can later override the frequency code. A separate async-pair register selects among the fixed AGP/PCI frequency pairs.

The programmed frequency code is merged with a power-save input to form the active code. The active code is then decoded into the CPU frequency class, a frequency band, a spread-spectrum mode, a tristate request and a test-mode request with its divider settings.

Each stop-gated clock group gets an output enable. Stop and power-down requests reach each group through a synchronizer clocked on the falling edge of that group's own clock. An enable can therefore only change while its clock is low, so the gated clock never shows a runt pulse.

Top module: `clkgen_ctrl`

## Requirements
- R1: While `pwrgd_n` is sampled low, the straps are captured on every `clk` edge. Once it is high they are held, and later strap changes have no effect on any output. `early_skew` equals the captured {E1,E3} pair, in steps of 0.5 ns: 0 gives 0 ns, 1 gives 0.5 ns, 2 gives 1.0 ns, 3 gives 1.5 ns. `async_en` is the inverse of the captured `strap_asel`.
- R2: `cpu_class` equals bits 1:0 of the active code: 0 for 100 MHz, 1 for 133 MHz, 2 for 200 MHz, 3 for 166 MHz. `band` comes from bits 4:2 of the active code: 0xx gives 0 (standard), 100 gives 1 (power-save), 101 gives 2 (+3%), 110 gives 3 (+5%), 111 gives 4 (+10%).
- R3: While `psave_n` is low, the active code is {100, programmed bits 1:0}. When `psave_n` goes high again, the programmed code returns unchanged. Outputs follow `psave_n` two `clk` edges later.
- R4: `spread` comes from bits 4:2 of the active code: 100 gives 0 (off), 000 gives 1 (0.3% center), 011 gives 2 (0.55% center), 001 gives 3 (-0.5% down), 010 gives 4 (-0.75% down), and 101, 110 and 111 give 1.
- R5: Active code 11010 sets `tristate` and forces `spread` to 0. Active code 11110 sets `test_mode`, forces `spread` to 0, and sets `tdiv_cpu`=1, `tdiv_agp`=2 and `tdiv_pci`=3 (log2 of dividers 2, 4 and 8). The `tdiv` outputs are 0 otherwise. `tristate` and `test_mode` are never both set.
- R6: A write with `wr_valid` and `wr_ovr_en` high, made while `pwrgd_n` is high, replaces the programmed code with `wr_fs`. With `wr_ovr_en` low the write leaves the code unchanged. Decoded outputs update two edges after the write.
- R7: Any `wr_valid` loads `agp_pci_sel` from `wr_async`: 0 gives 66/33 MHz, 1 gives 75.43/37.72 MHz, 2 gives 88/44 MHz. The reserved value 3 is stored as 0.
- R8: A low `grp_stop_n[g]` clears `grp_en[g]` by the second falling edge of `grp_clk[g]`, and leaves the other groups enabled. Raising it sets the enable again with the same latency.
- R9: `grp_en[g]` changes only while `grp_clk[g]` is low.
- R10: A low `pdown_n` clears every `grp_en` and sets `pd_active` two `clk` edges later.
- R11: Under `rst` all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrgd_n | input | 1 | Active-low power-good strobe (strap window) |
| strap_fs | input | 5 | Frequency-select straps |
| strap_early | input | 2 | Early-PCI straps {E1,E3} |
| strap_asel | input | 1 | Async AGP/PCI select strap |
| psave_n | input | 1 | Active-low power-save request |
| wr_valid | input | 1 | Register write strobe |
| wr_ovr_en | input | 1 | Frequency override enable bit of the write |
| wr_fs | input | 5 | Override frequency code |
| wr_async | input | 2 | Async AGP/PCI pair code |
| grp_clk | input | NUM_GRP | Clock of each stop-gated group |
| grp_stop_n | input | NUM_GRP | Active-low stop request per group |
| pdown_n | input | 1 | Active-low power-down |
| cpu_class | output | 2 | CPU frequency class |
| band | output | 3 | Frequency band |
| spread | output | 3 | Spread-spectrum mode |
| tristate | output | 1 | Tristate all outputs |
| test_mode | output | 1 | Test clock mode |
| tdiv_cpu | output | 2 | log2 CPU test divider |
| tdiv_agp | output | 2 | log2 AGP test divider |
| tdiv_pci | output | 2 | log2 PCI test divider |
| early_skew | output | 2 | Early-PCI skew step (0.5 ns units) |
| async_en | output | 1 | Async AGP/PCI source selected |
| agp_pci_sel | output | 2 | AGP/PCI frequency pair |
| grp_en | output | NUM_GRP | Output enable per gated group |
| pd_active | output | 1 | Power-down in effect |

## Verification
A corrupted programmed code or power-save flag reaches `band`, `spread` and `cpu_class` exactly two control edges after the stimulus. The bench samples those ports at that point, across the full spread table, both special codes and the overclock bands. A strap latch that keeps sampling after the window shows up as a changed `early_skew` or `cpu_class` right after the straps are moved. A wrong synchronizer depth or edge in a gate shows as a missing enable or a late one after several group-clock periods. It can also show as an enable edge seen while the group clock is high, which the bench watches continuously.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int FS_W   = 5;
  localparam int SKEW_W = 2;
  localparam int SEL_W  = 2;

  typedef enum logic [2:0] {
    SPR_OFF  = 3'd0,
    SPR_C030 = 3'd1,
    SPR_C055 = 3'd2,
    SPR_D050 = 3'd3,
    SPR_D075 = 3'd4
  } spread_e;

  typedef enum logic [2:0] {
    BND_STD  = 3'd0,
    BND_SAVE = 3'd1,
    BND_OC3  = 3'd2,
    BND_OC5  = 3'd3,
    BND_OC10 = 3'd4
  } band_e;

  localparam logic [FS_W-1:0] FS_TRISTATE = 5'b11010;
  localparam logic [FS_W-1:0] FS_TEST     = 5'b11110;
  localparam logic [2:0]      HI_SAVE     = 3'b100;

  typedef struct packed {
    logic [1:0] cpu_class;
    band_e      band;
    spread_e    spread;
    logic       tristate;
    logic       test_mode;
    logic [1:0] tdiv_cpu;
    logic [1:0] tdiv_agp;
    logic [1:0] tdiv_pci;
  } mode_t;
endpackage

// File: rtl/cg_strap_latch.sv
module cg_strap_latch
  import clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pwrgd_n,
  input  logic [FS_W-1:0]   strap_fs,
  input  logic [SKEW_W-1:0] strap_early,
  input  logic              strap_asel,
  input  logic              wr_valid,
  input  logic              wr_ovr_en,
  input  logic [FS_W-1:0]   wr_fs,
  input  logic [SEL_W-1:0]  wr_async,
  output logic [FS_W-1:0]   prog_fs,
  output logic [SKEW_W-1:0] early_skew,
  output logic              async_en,
  output logic [SEL_W-1:0]  agp_pci_sel
);
  localparam logic [SEL_W-1:0] SEL_RSVD = '1;

  logic window;
  assign window = ~pwrgd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_fs    <= '0;
      early_skew <= '0;
      async_en   <= 1'b0;
    end else if (window) begin
      prog_fs    <= strap_fs;
      early_skew <= strap_early;
      async_en   <= ~strap_asel;
    end else if (wr_valid && wr_ovr_en) begin
      prog_fs    <= wr_fs;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      agp_pci_sel <= '0;
    end else if (wr_valid) begin
      agp_pci_sel <= (wr_async == SEL_RSVD) ? '0 : wr_async;
    end
  end
endmodule

// File: rtl/cg_mode_decode.sv
module cg_mode_decode
  import clkgen_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [FS_W-1:0] prog_fs,
  input  logic            psave_n,
  output mode_t           mode
);
  logic            save_q;
  logic [FS_W-1:0] act_fs;
  mode_t           nxt;

  always_ff @(posedge clk) begin
    if (rst) save_q <= 1'b0;
    else     save_q <= ~psave_n;
  end

  assign act_fs = save_q ? {HI_SAVE, prog_fs[1:0]} : prog_fs;

  always_comb begin
    nxt           = '0;
    nxt.cpu_class = act_fs[1:0];
    case (act_fs[4:2])
      3'b100:  nxt.band = BND_SAVE;
      3'b101:  nxt.band = BND_OC3;
      3'b110:  nxt.band = BND_OC5;
      3'b111:  nxt.band = BND_OC10;
      default: nxt.band = BND_STD;
    endcase
    case (act_fs[4:2])
      3'b001:  nxt.spread = SPR_D050;
      3'b010:  nxt.spread = SPR_D075;
      3'b011:  nxt.spread = SPR_C055;
      3'b100:  nxt.spread = SPR_OFF;
      default: nxt.spread = SPR_C030;
    endcase
    if (act_fs == FS_TRISTATE) begin
      nxt.tristate = 1'b1;
      nxt.spread   = SPR_OFF;
    end
    if (act_fs == FS_TEST) begin
      nxt.test_mode = 1'b1;
      nxt.spread    = SPR_OFF;
      nxt.tdiv_cpu  = 2'd1;
      nxt.tdiv_agp  = 2'd2;
      nxt.tdiv_pci  = 2'd3;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= '0;
    else     mode <= nxt;
  end
endmodule

// File: rtl/cg_stop_gate.sv
module cg_stop_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic gclk,
  input  logic rst,
  input  logic stop_n,
  input  logic pdown_n,
  output logic en
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(negedge gclk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[LAST-1:0], stop_n & pdown_n};
  end

  assign en = chain[LAST];
endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int NUM_GRP     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwrgd_n,
  input  logic [4:0]         strap_fs,
  input  logic [1:0]         strap_early,
  input  logic               strap_asel,
  input  logic               psave_n,
  input  logic               wr_valid,
  input  logic               wr_ovr_en,
  input  logic [4:0]         wr_fs,
  input  logic [1:0]         wr_async,
  input  logic [NUM_GRP-1:0] grp_clk,
  input  logic [NUM_GRP-1:0] grp_stop_n,
  input  logic               pdown_n,
  output logic [1:0]         cpu_class,
  output logic [2:0]         band,
  output logic [2:0]         spread,
  output logic               tristate,
  output logic               test_mode,
  output logic [1:0]         tdiv_cpu,
  output logic [1:0]         tdiv_agp,
  output logic [1:0]         tdiv_pci,
  output logic [1:0]         early_skew,
  output logic               async_en,
  output logic [1:0]         agp_pci_sel,
  output logic [NUM_GRP-1:0] grp_en,
  output logic               pd_active
);
  localparam int PD_LAST = SYNC_STAGES - 1;

  logic [FS_W-1:0] prog_fs;
  mode_t           mode;
  logic [PD_LAST:0] pd_chain;

  cg_strap_latch u_latch (
    .clk         (clk),
    .rst         (rst),
    .pwrgd_n     (pwrgd_n),
    .strap_fs    (strap_fs),
    .strap_early (strap_early),
    .strap_asel  (strap_asel),
    .wr_valid    (wr_valid),
    .wr_ovr_en   (wr_ovr_en),
    .wr_fs       (wr_fs),
    .wr_async    (wr_async),
    .prog_fs     (prog_fs),
    .early_skew  (early_skew),
    .async_en    (async_en),
    .agp_pci_sel (agp_pci_sel)
  );

  cg_mode_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .prog_fs (prog_fs),
    .psave_n (psave_n),
    .mode    (mode)
  );

  assign cpu_class = mode.cpu_class;
  assign band      = mode.band;
  assign spread    = mode.spread;
  assign tristate  = mode.tristate;
  assign test_mode = mode.test_mode;
  assign tdiv_cpu  = mode.tdiv_cpu;
  assign tdiv_agp  = mode.tdiv_agp;
  assign tdiv_pci  = mode.tdiv_pci;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_gate
    cg_stop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .gclk    (grp_clk[g]),
      .rst     (rst),
      .stop_n  (grp_stop_n[g]),
      .pdown_n (pdown_n),
      .en      (grp_en[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) pd_chain <= '0;
    else     pd_chain <= {pd_chain[PD_LAST-1:0], ~pdown_n};
  end
  assign pd_active = pd_chain[PD_LAST];
endmodule

// File: rtl/clkgen_ctrl_chk.sv
module clkgen_ctrl_chk #(
  parameter int NUM_GRP = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               pwrgd_n,
  input logic               psave_n,
  input logic [2:0]         band,
  input logic [2:0]         spread,
  input logic               tristate,
  input logic               test_mode,
  input logic [1:0]         early_skew,
  input logic [1:0]         agp_pci_sel,
  input logic [NUM_GRP-1:0] grp_clk,
  input logic [NUM_GRP-1:0] grp_en
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk) begin
    if (rst) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (up_cnt != 2'd0 && $past(pwrgd_n)) |-> $stable(early_skew)); // R1

  AST_PSAVE_BAND: assert property (@(posedge clk) disable iff (rst)
    (up_cnt == 2'd3 && !$past(psave_n, 2)) |-> (band == 3'd1 && spread == 3'd0)); // R3

  AST_SPECIAL_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tristate, test_mode})); // R5

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    agp_pci_sel != 2'b11); // R7

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    AST_EN_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
      (up_cnt != 2'd0 && grp_en[g] != $past(grp_en[g])) |-> !grp_clk[g]); // R9
  end
endmodule

bind clkgen_ctrl clkgen_ctrl_chk #(.NUM_GRP(NUM_GRP)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwrgd_n     (pwrgd_n),
  .psave_n     (psave_n),
  .band        (band),
  .spread      (spread),
  .tristate    (tristate),
  .test_mode   (test_mode),
  .early_skew  (early_skew),
  .agp_pci_sel (agp_pci_sel),
  .grp_clk     (grp_clk),
  .grp_en      (grp_en)
);

// File: tb/clkgen_ctrl_test.sv
`timescale 1ns/1ps
module clkgen_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwrgd_n = 1'b1;
  logic [4:0] strap_fs = '0;
  logic [1:0] strap_early = '0;
  logic       strap_asel = 1'b1;
  logic       psave_n = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ovr_en = 1'b0;
  logic [4:0] wr_fs = '0;
  logic [1:0] wr_async = '0;
  logic [1:0] grp_clk = '0;
  logic [1:0] grp_stop_n = 2'b11;
  logic       pdown_n = 1'b1;
  logic [1:0] cpu_class;
  logic [2:0] band, spread;
  logic       tristate, test_mode;
  logic [1:0] tdiv_cpu, tdiv_agp, tdiv_pci;
  logic [1:0] early_skew;
  logic       async_en;
  logic [1:0] agp_pci_sel;
  logic [1:0] grp_en;
  logic       pd_active;

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  logic [1:0] en_prev = '0;

  always #2.5 clk = ~clk;
  always #10  grp_clk[0] = ~grp_clk[0];
  always #15  grp_clk[1] = ~grp_clk[1];

  clkgen_ctrl uut (.*);

  // R9: enable edges seen while the group clock is high are counted
  always @(grp_en) begin
    for (int g = 0; g < 2; g++)
      if (!rst && grp_en[g] != en_prev[g] && grp_clk[g]) glitches++;
    en_prev = grp_en;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_fs(input logic [4:0] fs, input logic ovr);
    wr_fs = fs; wr_ovr_en = ovr; wr_async = agp_pci_sel; wr_valid = 1'b1;
    cyc(1);
    wr_valid = 1'b0; wr_ovr_en = 1'b0;
    cyc(3);
  endtask

  task automatic t_reset;
    cyc(4);
    chk("R11 cpu_class", cpu_class, 0);
    chk("R11 spread", spread, 0);
    chk("R11 early_skew", early_skew, 0);
    chk("R11 grp_en", grp_en, 0);
    chk("R11 pd_active", pd_active, 0);
    rst = 1'b0;
    cyc(2);
  endtask

  task automatic t_strap;
    pwrgd_n = 1'b0;
    strap_fs = 5'b01101; strap_early = 2'b10; strap_asel = 1'b0;
    cyc(2);
    pwrgd_n = 1'b1;
    cyc(1);
    strap_fs = 5'b00010; strap_early = 2'b01; strap_asel = 1'b1;
    cyc(4);
    chk("R1 early_skew", early_skew, 2);
    chk("R1 async_en", async_en, 1);
    chk("R1 cpu_class", cpu_class, 1);
    chk("R4 spread 011", spread, 2);
    chk("R2 band std", band, 0);
  endtask

  task automatic t_decode;
    write_fs(5'b00000, 1'b1);
    chk("R4 spread 000", spread, 1);
    chk("R2 class 00", cpu_class, 0);
    write_fs(5'b00110, 1'b1);
    chk("R4 spread 001", spread, 3);
    chk("R2 class 10", cpu_class, 2);
    write_fs(5'b01011, 1'b1);
    chk("R4 spread 010", spread, 4);
    write_fs(5'b10011, 1'b1);
    chk("R4 spread 100", spread, 0);
    chk("R2 band save", band, 1);
    chk("R2 class 11", cpu_class, 3);
    write_fs(5'b10110, 1'b1);
    chk("R2 band oc3", band, 2);
    chk("R4 spread 101", spread, 1);
    write_fs(5'b11001, 1'b1);
    chk("R2 band oc5", band, 3);
    chk("R4 spread 110", spread, 1);
    chk("R5 no tristate", tristate, 0);
    write_fs(5'b11010, 1'b1);
    chk("R5 tristate", tristate, 1);
    chk("R5 tristate spread", spread, 0);
    chk("R5 tristate no test", test_mode, 0);
    write_fs(5'b11110, 1'b1);
    chk("R5 test_mode", test_mode, 1);
    chk("R5 tdiv_cpu", tdiv_cpu, 1);
    chk("R5 tdiv_agp", tdiv_agp, 2);
    chk("R5 tdiv_pci", tdiv_pci, 3);
    chk("R5 test spread", spread, 0);
    write_fs(5'b11111, 1'b1);
    chk("R2 band oc10", band, 4);
    chk("R5 tdiv cleared", tdiv_pci, 0);
    write_fs(5'b00001, 1'b0);
    chk("R6 no override band", band, 4);
    chk("R6 no override class", cpu_class, 3);
  endtask

  task automatic t_latency;
    wr_fs = 5'b01000; wr_ovr_en = 1'b1; wr_async = agp_pci_sel; wr_valid = 1'b1;
    cyc(1);
    wr_valid = 1'b0; wr_ovr_en = 1'b0;
    chk("R6 not yet", spread, 1);
    cyc(1);
    chk("R6 after two edges", spread, 4);
  endtask

  task automatic t_psave;
    write_fs(5'b11101, 1'b1);
    chk("R3 before", band, 4);
    psave_n = 1'b0;
    cyc(1);
    chk("R3 one edge", band, 4);
    cyc(1);
    chk("R3 band save", band, 1);
    chk("R3 spread off", spread, 0);
    chk("R3 class kept", cpu_class, 1);
    psave_n = 1'b1;
    cyc(3);
    chk("R3 restored band", band, 4);
    chk("R3 restored spread", spread, 1);
  endtask

  task automatic t_async;
    wr_async = 2'b01; wr_ovr_en = 1'b0; wr_valid = 1'b1; cyc(1);
    wr_valid = 1'b0; cyc(1);
    chk("R7 sel 01", agp_pci_sel, 1);
    wr_async = 2'b11; wr_valid = 1'b1; cyc(1);
    wr_valid = 1'b0; cyc(1);
    chk("R7 sel rsvd", agp_pci_sel, 0);
    wr_async = 2'b10; wr_valid = 1'b1; cyc(1);
    wr_valid = 1'b0; cyc(1);
    chk("R7 sel 10", agp_pci_sel, 2);
    chk("R6 async write keeps code", band, 4);
  endtask

  task automatic t_stop;
    cyc(20);
    chk("R8 both enabled", grp_en, 3);
    grp_stop_n[0] = 1'b0;
    cyc(16);
    chk("R8 group0 stopped", grp_en, 2);
    grp_stop_n[0] = 1'b1;
    cyc(16);
    chk("R8 group0 restarted", grp_en, 3);
    grp_stop_n[1] = 1'b0;
    cyc(20);
    chk("R8 group1 stopped", grp_en, 1);
    grp_stop_n[1] = 1'b1;
    cyc(20);
    pdown_n = 1'b0;
    cyc(2);
    chk("R10 pd_active", pd_active, 1);
    cyc(20);
    chk("R10 all disabled", grp_en, 0);
    pdown_n = 1'b1;
    cyc(24);
    chk("R10 pd released", pd_active, 0);
    chk("R8 reenabled", grp_en, 3);
    chk("R9 glitch-free enables", glitches, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_strap();
    t_decode();
    t_latency();
    t_psave();
    t_async();
    t_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule